// File: doc/BRIEF.md
# RTC Alarm and Interrupt Unit

This unit sits beside a real-time-clock counter and handles its alarm comparison and its interrupt status. It holds alarm bytes for seconds, minutes and hours, plus optional day-of-month and month alarm bytes. It compares them with the current time fields from the counter on every update tick. It keeps a control byte with three interrupt enables (periodic, alarm, update) and a flags byte with three matching event flags and a summary bit. It drives one interrupt line.

Software reaches the unit through a byte-wide register port with separate read and write strobes. Read data is registered and appears one cycle after the read strobe. An alarm byte whose two top bits are both set means "any value" for that field. This lets software build per-second, per-minute or daily alarms. The flags register clears itself when it is read. The counter, its rate divider and any battery-backed storage live outside the block. The unit receives the current time bytes and one-cycle update and periodic tick pulses from them.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset the control byte (address 0x0B) and the flags byte (address 0x0C) read as 0x00, and `irq` is low.
- R2: The seconds, minutes and hours alarm bytes at addresses 0x01, 0x03 and 0x05 and the control byte at 0x0B read back the value last written. Read data appears on `rdata` in the cycle after `rd_en`.
- R3: The alarm flag (flags bit 5) becomes set in the cycle after an `update_tick` on which every alarm field matches its time field. Without an update tick, no alarm flag is raised, even when all fields are equal.
- R4: An alarm byte with bits [7:6] equal to 2'b11 (0xC0 to 0xFF) matches every value of its time field.
- R5: The day alarm byte (address `DAY_ADDR`, default 0x0D) reads back with bits [7:6] as zero. When bits [7:6] are not 2'b11, only its low six bits are compared with the day field. A low-six-bit value of zero, or bits [7:6] of 2'b11, matches any day.
- R6: The month alarm byte (address `MON_ADDR`, default 0x32) matches any month when it is 0x00 or has bits [7:6] of 2'b11. Otherwise it must equal the month field.
- R7: Each `update_tick` sets the update flag (flags bit 4). Each `periodic_tick` sets the periodic flag (flags bit 6).
- R8: Event flags latch whether or not their enable is set. Control bits 6, 5 and 4 enable the periodic, alarm and update flags respectively.
- R9: `irq` and the summary bit (flags bit 7) are high exactly when at least one flag is set together with its enable. This includes a flag set before its enable was written.
- R10: A read of the flags byte returns the flags and clears all of them, which drops `irq`. An event arriving in the same cycle as that read is kept for the next read.
- R11: Writes to the flags byte have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW (8) | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| cur_sec | input | 8 | Current seconds from the counter |
| cur_min | input | 8 | Current minutes |
| cur_hour | input | 8 | Current hours |
| cur_mday | input | 8 | Current day of month |
| cur_mon | input | 8 | Current month |
| update_tick | input | 1 | One-cycle pulse per time update |
| periodic_tick | input | 1 | One-cycle pulse per periodic period |
| irq | output | 1 | Interrupt request, active high |

## Verification
On every cycle the assertions check four things. Each tick raises its flag on the following edge. The alarm flag rises only after an update tick that coincides with a match. A quiet flags read leaves all flags clear. The interrupt line never stands without an enabled flag behind it. The bench's scenarios are needed for the rest. They sweep the compare rules over whole field ranges and cover the don't-care codes and the day and month unused encodings. They also cover readback masking, an enable written after its flag, a read colliding with a tick, and the ignored write to the flags byte.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  // bit positions shared by the control byte and the flags byte
  localparam int BIT_PER = 6;
  localparam int BIT_ALM = 5;
  localparam int BIT_UPD = 4;
  localparam int BIT_SUM = 7;
  localparam int NEV     = 3;

  // top two bits set: field is a wildcard
  function automatic logic is_wild(input logic [7:0] a);
    return a[7:6] == 2'b11;
  endfunction

  function automatic logic hms_hit(input logic [7:0] a, input logic [7:0] c);
    return is_wild(a) || (a == c);
  endfunction

  function automatic logic day_hit(input logic [7:0] a, input logic [7:0] c);
    return is_wild(a) || (a[5:0] == 6'd0) || ({2'b00, a[5:0]} == c);
  endfunction

  function automatic logic mon_hit(input logic [7:0] a, input logic [7:0] c);
    return is_wild(a) || (a == 8'h00) || (a == c);
  endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs #(
  parameter int AW       = 8,
  parameter int DAY_ADDR = 'h0D,
  parameter int MON_ADDR = 'h32,
  parameter bit HAS_DAY  = 1'b1,
  parameter bit HAS_MON  = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    alm_sec,
  output logic [7:0]    alm_min,
  output logic [7:0]    alm_hr,
  output logic [7:0]    alm_day,
  output logic [7:0]    alm_mon,
  output logic [7:0]    ctrl
);
  localparam logic [AW-1:0] A_SEC  = AW'(1);
  localparam logic [AW-1:0] A_MIN  = AW'(3);
  localparam logic [AW-1:0] A_HR   = AW'(5);
  localparam logic [AW-1:0] A_CTRL = AW'(11);
  localparam logic [AW-1:0] A_DAY  = AW'(DAY_ADDR);
  localparam logic [AW-1:0] A_MON  = AW'(MON_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_sec <= 8'h00;
      alm_min <= 8'h00;
      alm_hr  <= 8'h00;
      ctrl    <= 8'h00;
    end else if (wr_en) begin
      if (addr == A_SEC)  alm_sec <= wdata;
      if (addr == A_MIN)  alm_min <= wdata;
      if (addr == A_HR)   alm_hr  <= wdata;
      if (addr == A_CTRL) ctrl    <= wdata;
    end
  end

  generate
    if (HAS_DAY) begin : g_day
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alm_day <= 8'h00;
        else if (wr_en && addr == A_DAY) alm_day <= wdata;
      end
    end else begin : g_no_day
      assign alm_day = 8'h00;  // zero = unused, matches any day
    end
    if (HAS_MON) begin : g_mon
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alm_mon <= 8'h00;
        else if (wr_en && addr == A_MON) alm_mon <= wdata;
      end
    end else begin : g_no_mon
      assign alm_mon = 8'h00;
    end
  endgenerate
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hr,
  input  logic [7:0] alm_day,
  input  logic [7:0] alm_mon,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] cur_mday,
  input  logic [7:0] cur_mon,
  output logic       hit
);
  always_comb begin
    hit = hms_hit(alm_sec, cur_sec) && hms_hit(alm_min, cur_min) &&
          hms_hit(alm_hr, cur_hour) && day_hit(alm_day, cur_mday) &&
          mon_hit(alm_mon, cur_mon);
  end
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int NEV = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] set_ev,
  input  logic           clr,
  input  logic [NEV-1:0] en,
  output logic [NEV-1:0] flags,
  output logic           pending
);
  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (clr ? '0 : flags) | set_ev;
  end

  assign pending = |(flags & en);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DAY_ADDR = 'h0D,
  parameter int MON_ADDR = 'h32,
  parameter bit HAS_DAY  = 1'b1,
  parameter bit HAS_MON  = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic [7:0]    cur_sec,
  input  logic [7:0]    cur_min,
  input  logic [7:0]    cur_hour,
  input  logic [7:0]    cur_mday,
  input  logic [7:0]    cur_mon,
  input  logic          update_tick,
  input  logic          periodic_tick,
  output logic          irq
);
  localparam logic [AW-1:0] A_SEC  = AW'(1);
  localparam logic [AW-1:0] A_MIN  = AW'(3);
  localparam logic [AW-1:0] A_HR   = AW'(5);
  localparam logic [AW-1:0] A_CTRL = AW'(11);
  localparam logic [AW-1:0] A_FLG  = AW'(12);
  localparam logic [AW-1:0] A_DAY  = AW'(DAY_ADDR);
  localparam logic [AW-1:0] A_MON  = AW'(MON_ADDR);

  logic [7:0]     alm_sec, alm_min, alm_hr, alm_day, alm_mon, ctrl;
  logic           alarm_hit;   // fields match now
  logic [NEV-1:0] ev_w;        // {periodic, alarm, update} events this cycle
  logic [NEV-1:0] ie_w;        // enables in same order
  logic [NEV-1:0] flag_q;
  logic           pend_w;
  logic           flag_rd;     // flags read: clear-on-read strobe
  logic [7:0]     rd_mux;

  rtc_alarm_regs #(
    .AW(AW), .DAY_ADDR(DAY_ADDR), .MON_ADDR(MON_ADDR),
    .HAS_DAY(HAS_DAY), .HAS_MON(HAS_MON)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
    .alm_day(alm_day), .alm_mon(alm_mon), .ctrl(ctrl)
  );

  rtc_alarm_match u_match (
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
    .alm_day(alm_day), .alm_mon(alm_mon),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_mday(cur_mday), .cur_mon(cur_mon), .hit(alarm_hit)
  );

  assign ev_w    = {periodic_tick, update_tick & alarm_hit, update_tick};
  assign ie_w    = {ctrl[BIT_PER], ctrl[BIT_ALM], ctrl[BIT_UPD]};
  assign flag_rd = rd_en && (addr == A_FLG);

  rtc_irq_flags #(.NEV(NEV)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_ev(ev_w), .clr(flag_rd),
    .en(ie_w), .flags(flag_q), .pending(pend_w)
  );

  assign irq = pend_w;

  always_comb begin
    rd_mux = 8'h00;
    if (addr == A_SEC)  rd_mux = alm_sec;
    if (addr == A_MIN)  rd_mux = alm_min;
    if (addr == A_HR)   rd_mux = alm_hr;
    if (addr == A_CTRL) rd_mux = ctrl;
    if (addr == A_FLG)  rd_mux = {pend_w, flag_q, 4'h0};
    if (HAS_DAY && addr == A_DAY) rd_mux = {2'b00, alm_day[5:0]};
    if (HAS_MON && addr == A_MON) rd_mux = alm_mon;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/rtc_alarm_sva.sv
module rtc_alarm_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       update_tick,
  input logic       periodic_tick,
  input logic       flag_rd,
  input logic       irq,
  input logic [2:0] flags,   // {periodic, alarm, update}
  input logic [2:0] ie,
  input logic       alarm_hit
);
  // R1: flags and line idle while in reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (flags == 3'b000 && !irq));

  // R7
  a_r7_update_sets: assert property (@(posedge clk) disable iff (!rst_n)
    update_tick |=> flags[0]);
  a_r7_periodic_sets: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_tick |=> flags[2]);

  // R3
  a_r3_alarm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (update_tick && alarm_hit) |=> flags[1]);
  a_r3_alarm_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(update_tick && alarm_hit));

  // R10
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !update_tick && !periodic_tick) |=> (flags == 3'b000 && !irq));

  // R9
  a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((flags & ie) != 3'b000));
endmodule

bind rtc_alarm_irq rtc_alarm_sva u_sva (
  .clk(clk), .rst_n(rst_n), .update_tick(update_tick),
  .periodic_tick(periodic_tick), .flag_rd(flag_rd), .irq(irq),
  .flags(flag_q), .ie(ie_w), .alarm_hit(alarm_hit)
);

// File: tb/tb_rtc_alarm_irq.sv
module tb_rtc_alarm_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, update_tick = 0, periodic_tick = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_mday = 0, cur_mon = 0;
  logic irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  rtc_alarm_irq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_mday(cur_mday), .cur_mon(cur_mon),
    .update_tick(update_tick), .periodic_tick(periodic_tick), .irq(irq)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction
  // bench's own view of the compare rules
  function automatic bit m_hms(input int a, input int c);
    return (a >= 192) || (a == c);
  endfunction
  function automatic bit m_day(input int a, input int c);
    return (a >= 192) || ((a % 64) == 0) || ((a % 64) == c);
  endfunction
  function automatic bit m_mon(input int a, input int c);
    return (a >= 192) || (a == 0) || (a == c);
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic utick();
    @(negedge clk); update_tick = 1;
    @(negedge clk); update_tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(8'h0B, d); chk(d, 8'h00, "R1 ctrl");
    rd(8'h0C, d); chk(d, 8'h00, "R1 flags");
    chk({7'd0, irq}, 8'h00, "R1 irq");
    // R2
    wr(8'h01, 8'h37); wr(8'h03, 8'h42); wr(8'h05, 8'h19); wr(8'h0B, 8'h02);
    rd(8'h01, d); chk(d, 8'h37, "R2 sec");
    rd(8'h03, d); chk(d, 8'h42, "R2 min");
    rd(8'h05, d); chk(d, 8'h19, "R2 hour");
    rd(8'h0B, d); chk(d, 8'h02, "R2 ctrl");
    // R3 with no tick: all equal, no flag
    cur_sec = 8'h37; cur_min = 8'h42; cur_hour = 8'h19;
    repeat (3) @(negedge clk);
    rd(8'h0C, d); chk(d, 8'h00, "R3 no tick");
    // R3 sweep of seconds, minutes/hours wildcard
    wr(8'h03, 8'hFF); wr(8'h05, 8'hC0);
    for (int v = 0; v < 60; v++) begin
      wr(8'h01, to_bcd(v));
      for (int k = 0; k < 2; k++) begin
        cur_sec = to_bcd((v + k) % 60);
        utick();
        rd(8'h0C, d);
        chk(d, m_hms(int'(to_bcd(v)), int'(cur_sec)) ? 8'h30 : 8'h10, "R3 sec sweep");
      end
    end
    // R4 sweep over every wildcard code on the hours byte
    wr(8'h01, 8'hFF);
    for (int a = 192; a < 256; a++) begin
      wr(8'h05, 8'(a));
      cur_hour = to_bcd(a % 24);
      utick();
      rd(8'h0C, d); chk(d, 8'h30, "R4 wildcard");
    end
    // R4 non-wildcard near the boundary (0xBF) does not match
    wr(8'h05, 8'hBF); cur_hour = 8'h23; utick();
    rd(8'h0C, d); chk(d, 8'h10, "R4 0xBF exact");
    wr(8'h05, 8'hC0);
    // R5 day alarm
    wr(8'h0D, 8'hC5); rd(8'h0D, d); chk(d, 8'h05, "R5 readback");
    for (int a = 0; a < 256; a += 17) begin
      wr(8'h0D, 8'(a));
      for (int c = 1; c < 32; c += 10) begin
        cur_mday = 8'(c); utick(); rd(8'h0C, d);
        chk(d, m_day(a, c) ? 8'h30 : 8'h10, "R5 day match");
      end
    end
    wr(8'h0D, 8'h00);
    // R6 month alarm
    for (int a = 0; a < 256; a += 15) begin
      wr(8'h32, 8'(a));
      for (int c = 0; c < 16; c += 5) begin
        cur_mon = 8'(c); utick(); rd(8'h0C, d);
        chk(d, m_mon(a, c) ? 8'h30 : 8'h10, "R6 month match");
      end
    end
    // full five-field alarm
    wr(8'h01, 8'h58); wr(8'h03, 8'h59); wr(8'h05, 8'h23);
    wr(8'h0D, 8'h31); wr(8'h32, 8'h12);
    cur_sec = 8'h58; cur_min = 8'h59; cur_hour = 8'h23; cur_mday = 8'h31; cur_mon = 8'h12;
    utick(); rd(8'h0C, d); chk(d, 8'h30, "R3 all fields");
    cur_mon = 8'h11; utick(); rd(8'h0C, d); chk(d, 8'h10, "R6 month differs");
    // R7/R8 flags latch with enables clear
    @(negedge clk); periodic_tick = 1; @(negedge clk); periodic_tick = 0;
    chk({7'd0, irq}, 8'h00, "R8 no irq when disabled");
    rd(8'h0C, d); chk(d, 8'h40, "R7 periodic flag");
    // R9 enable after flag raises irq
    utick();
    chk({7'd0, irq}, 8'h00, "R8 update latched quietly");
    wr(8'h0B, 8'h12);
    chk({7'd0, irq}, 8'h01, "R9 late enable");
    // R10 read returns with summary then clears
    rd(8'h0C, d); chk(d, 8'h90, "R10 read value");
    chk({7'd0, irq}, 8'h00, "R10 irq dropped");
    // R9 other enable does not fire
    wr(8'h0B, 8'h62);
    utick();
    chk({7'd0, irq}, 8'h00, "R9 unrelated enable");
    rd(8'h0C, d); chk(d, 8'h10, "R9 no summary");
    // R10 event in same cycle as read
    @(negedge clk); addr = 8'h0C; rd_en = 1; update_tick = 1;
    @(negedge clk); rd_en = 0; update_tick = 0; d = rdata;
    chk(d, 8'h00, "R10 collide old value");
    rd(8'h0C, d); chk(d, 8'h10, "R10 collide kept");
    // R11 write to flags ignored
    @(negedge clk); periodic_tick = 1; @(negedge clk); periodic_tick = 0;
    wr(8'h0C, 8'h00); wr(8'h0C, 8'hF0);
    chk({7'd0, irq}, 8'h01, "R11 irq unaffected");
    rd(8'h0C, d); chk(d, 8'hC0, "R11 flags unchanged");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule